// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor core that uses overlapping register windows. It keeps eight global registers, which every window sees, and a circular stack of `NWIN` windowed sets of sixteen registers each. A current-window pointer picks which set is visible. Each access names one of 32 architectural registers with a 5-bit number, and the block turns that number and the pointer into an entry of one physical array of `8 + 16*NWIN` words.

A window's outgoing registers are the same storage as the incoming registers of the window one step below it. A caller therefore writes its arguments into its outs, and the callee, after a save, reads them from its ins, with no copy. Save and restore move the pointer down or up by one, wrapping round the stack. A mask names windows that may not be entered. A move into a masked window is refused and reported on an overflow or underflow flag. Spilling and filling windows is left to trap software outside the block.

Every pin carries a fixed meaning in every cycle. Reads are combinational, the write port is a plain enable, and there is no flow control and no back-pressure at any port.

Top module: `winreg_file`

## Requirements
- R1: After reset the window pointer is 0, both flags are low and all 32 architectural registers read zero.
- R2: Architectural register 0 always reads zero, and a write to it has no effect.
- R3: Numbers 1–7 name global registers. The same storage is seen from every window.
- R4: Numbers 16–23 are locals and 24–31 are ins of the current window. Locals of different windows are distinct storage.
- R5: Numbers 8–15 are outs. Out k of window w is the same storage as in k (number 24+k) of window (w−1) mod NWIN.
- R6: A save alone, into a window whose mask bit is 0, sets the pointer to (pointer−1) mod NWIN, so 0 goes to NWIN−1.
- R7: A restore alone, into a window whose mask bit is 0, sets the pointer to (pointer+1) mod NWIN, so NWIN−1 goes to 0.
- R8: A save alone whose target window has mask bit 1 leaves the pointer unchanged and raises `overflow` for exactly the next cycle.
- R9: A restore alone whose target window has mask bit 1 leaves the pointer unchanged and raises `underflow` for exactly the next cycle.
- R10: A read of the register written in the same cycle returns the old value. The new value is readable from the next cycle.
- R11: Save and restore asserted together do nothing: the pointer holds and neither flag rises.
- R12: A write in the same cycle as a save or restore uses the window in effect before the move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 5 | Architectural number for read port A |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_idx | input | 5 | Architectural number for read port B |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural number to write |
| wr_data | input | 32 | Write data |
| save_req | input | 1 | Move the window pointer down by one |
| restore_req | input | 1 | Move the window pointer up by one |
| win_invalid | input | NWIN | Bit w set: window w may not be entered |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| overflow | output | 1 | One-cycle pulse after a refused save |
| underflow | output | 1 | One-cycle pulse after a refused restore |

## Verification
Read data is due in the same cycle as the index, so the bench applies inputs just after a falling edge and samples the read ports 1 ns later, before the rising edge. That sample must still show the value from before any write in that cycle. The pointer, both flags and the effect of a write are due one rising edge later, and the bench checks them at the next falling edge against a model it updates only at that edge. Random cycles mix writes, reads, saves, restores and changing masks. Directed sequences cover the wrap at both ends of the stack, refused moves, simultaneous save and restore, and writes issued together with a move.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int XLEN    = 32;
  localparam int NGLOB   = 8;
  localparam int SET_REGS = 16;
  localparam int GRP_SZ  = 8;
  localparam int AW      = 5;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN),
  parameter int PW   = $clog2(NGLOB + SET_REGS * NWIN)
) (
  input  logic [AW-1:0] arch,
  input  logic [CW-1:0] cwp,
  output logic [PW-1:0] phys
);
  reg_grp_e     grp;
  logic [2:0]   slot;
  logic [CW-1:0] below;
  logic [PW-1:0] cur_base;
  logic [PW-1:0] below_base;

  assign grp  = reg_grp_e'(arch[4:3]);
  assign slot = arch[2:0];

  // window one step below the current one, wrapping at zero
  always_comb begin
    if (cwp == '0) below = CW'(NWIN - 1);
    else           below = cwp - 1'b1;
  end

  // set w starts after the globals: locals first, then ins
  assign cur_base   = PW'(NGLOB) + (PW'(cwp) << 4);
  assign below_base = PW'(NGLOB) + (PW'(below) << 4);

  always_comb begin
    unique case (grp)
      GRP_GLOBAL: phys = PW'(slot);
      GRP_OUT:    phys = below_base + PW'(GRP_SZ) + PW'(slot);
      GRP_LOCAL:  phys = cur_base + PW'(slot);
      GRP_IN:     phys = cur_base + PW'(GRP_SZ) + PW'(slot);
      default:    phys = '0;
    endcase
  end
endmodule

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic [NWIN-1:0] win_invalid,
  output logic [CW-1:0]   cwp,
  output logic            overflow,
  output logic            underflow
);
  logic [CW-1:0] dn_tgt;
  logic [CW-1:0] up_tgt;
  logic          do_save;
  logic          do_rest;
  logic          save_blocked;
  logic          rest_blocked;

  always_comb begin
    dn_tgt = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
    up_tgt = (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;
  end

  assign do_save      = save_req & ~restore_req;
  assign do_rest      = restore_req & ~save_req;
  assign save_blocked = win_invalid[dn_tgt];
  assign rest_blocked = win_invalid[up_tgt];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp       <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= do_save & save_blocked;
      underflow <= do_rest & rest_blocked;
      if (do_save && !save_blocked)      cwp <= dn_tgt;
      else if (do_rest && !rest_blocked) cwp <= up_tgt;
    end
  end
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int NPHYS = 136,
  parameter int PW    = $clog2(NPHYS),
  parameter int XLEN  = 32,
  parameter int NRD   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRD-1:0][PW-1:0]    rd_addr,
  output logic [NRD-1:0][XLEN-1:0]  rd_data,
  input  logic                      wr_en,
  input  logic [PW-1:0]             wr_addr,
  input  logic [XLEN-1:0]           wr_data
);
  logic [XLEN-1:0] mem [NPHYS];

  for (genvar e = 0; e < NPHYS; e++) begin : g_ent
    if (e == 0) begin : g_zero
      assign mem[e] = '0;
    end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              mem[e] <= '0;
        else if (wr_en && wr_addr == PW'(e))     mem[e] <= wr_data;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = mem[rd_addr[p]];
  end
endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW    = $clog2(NWIN),
  localparam int NPHYS = NGLOB + SET_REGS * NWIN,
  localparam int PW    = $clog2(NPHYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_a_idx,
  output logic [31:0]     rd_a_data,
  input  logic [4:0]      rd_b_idx,
  output logic [31:0]     rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_idx,
  input  logic [31:0]     wr_data,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic [NWIN-1:0] win_invalid,
  output logic [CW-1:0]   cwp_o,
  output logic            overflow,
  output logic            underflow
);
  localparam int NPORT = 3;

  logic [NPORT-1:0][AW-1:0]  arch_idx;
  logic [NPORT-1:0][PW-1:0]  phys_idx;
  logic [1:0][XLEN-1:0]      rdata;
  logic [CW-1:0]             cwp;

  assign arch_idx[0] = rd_a_idx;
  assign arch_idx[1] = rd_b_idx;
  assign arch_idx[2] = wr_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    wrf_addr_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
      .arch (arch_idx[p]),
      .cwp  (cwp),
      .phys (phys_idx[p])
    );
  end

  wrf_window_ctl #(.NWIN(NWIN), .CW(CW)) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .win_invalid (win_invalid),
    .cwp         (cwp),
    .overflow    (overflow),
    .underflow   (underflow)
  );

  wrf_storage #(.NPHYS(NPHYS), .PW(PW), .XLEN(XLEN), .NRD(2)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr ({phys_idx[1], phys_idx[0]}),
    .rd_data (rdata),
    .wr_en   (wr_en && (wr_idx != '0)),
    .wr_addr (phys_idx[2]),
    .wr_data (wr_data)
  );

  assign rd_a_data = rdata[0];
  assign rd_b_data = rdata[1];
  assign cwp_o     = cwp;
endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk #(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      rd_a_idx,
  input logic [31:0]     rd_a_data,
  input logic [4:0]      rd_b_idx,
  input logic [31:0]     rd_b_data,
  input logic            save_req,
  input logic            restore_req,
  input logic [NWIN-1:0] win_invalid,
  input logic [CW-1:0]   cwp_o,
  input logic            overflow,
  input logic            underflow
);
  function automatic logic [CW-1:0] dn(input logic [CW-1:0] c);
    return (c == '0) ? CW'(NWIN - 1) : c - 1'b1;
  endfunction
  function automatic logic [CW-1:0] up(input logic [CW-1:0] c);
    return (c == CW'(NWIN - 1)) ? '0 : c + 1'b1;
  endfunction

  // R1
  cwp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cwp_o) < NWIN);

  // R2
  zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> (rd_a_data == 32'd0));

  // R2
  zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == 5'd0) |-> (rd_b_data == 32'd0));

  // R6
  save_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !restore_req && !win_invalid[dn(cwp_o)]) |=> (cwp_o == dn($past(cwp_o))));

  // R7
  restore_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !win_invalid[up(cwp_o)]) |=> (cwp_o == up($past(cwp_o))));

  // R8
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !restore_req && win_invalid[dn(cwp_o)]) |=> (overflow && $stable(cwp_o)));

  // R9
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && win_invalid[up(cwp_o)]) |=> (underflow && $stable(cwp_o)));

  // R11
  both_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req) |=> ($stable(cwp_o) && !overflow && !underflow));

  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({overflow, underflow}));
endmodule

bind winreg_file winreg_file_chk #(.NWIN(NWIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .rd_b_idx    (rd_b_idx),
  .rd_b_data   (rd_b_data),
  .save_req    (save_req),
  .restore_req (restore_req),
  .win_invalid (win_invalid),
  .cwp_o       (cwp_o),
  .overflow    (overflow),
  .underflow   (underflow)
);

// File: tb/sim_winreg_file.sv
`timescale 1ns/1ps
module sim_winreg_file;
  localparam int NW    = 8;
  localparam int CW    = $clog2(NW);
  localparam int NPHYS = 8 + 16 * NW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0]   rd_a_data, rd_b_data, wr_data = '0;
  logic          wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
  logic [NW-1:0] win_invalid = '0;
  logic [CW-1:0] cwp_o;
  logic          overflow, underflow;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [31:0] m [NPHYS];
  int  mcwp = 0;
  bit  eovf = 0, eunf = 0;

  always #5 clk = ~clk;

  winreg_file #(.NWIN(NW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req),
    .win_invalid(win_invalid), .cwp_o(cwp_o),
    .overflow(overflow), .underflow(underflow)
  );

  function automatic int phys(int w, int r);
    int k = r % 8;
    if (r < 8)  return r;
    if (r < 16) return 8 + 16 * ((w + NW - 1) % NW) + 8 + k;
    if (r < 24) return 8 + 16 * w + k;
    return 8 + 16 * w + 8 + k;
  endfunction

  function automatic logic [31:0] mread(int r);
    if (r == 0) return 32'd0;
    return m[phys(mcwp, r)];
  endfunction

  function automatic string rtag(int r, bit clash);
    if (clash)  return "R10";
    if (r == 0) return "R2";
    if (r < 8)  return "R3";
    if (r < 16) return "R5";
    return "R4";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(int r, string tag, logic [31:0] exp);
    rd_a_idx = 5'(r);
    #1;
    chk(tag, rd_a_data, exp);
  endtask

  // one cycle: inputs applied after a falling edge
  task automatic cyc(int ra, int rb, bit we, int wi, logic [31:0] wd, bit sv, bit rs);
    int t;
    rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    wr_en = we; wr_idx = 5'(wi); wr_data = wd;
    save_req = sv; restore_req = rs;
    #1;
    chk(rtag(ra, we && wi == ra && wi != 0), rd_a_data, mread(ra));
    chk(rtag(rb, we && wi == rb && wi != 0), rd_b_data, mread(rb));
    @(posedge clk);
    if (we && wi != 0) m[phys(mcwp, wi)] = wd;
    eovf = 0; eunf = 0;
    if (sv && !rs) begin
      t = (mcwp + NW - 1) % NW;
      if (win_invalid[t]) eovf = 1; else mcwp = t;
    end else if (rs && !sv) begin
      t = (mcwp + 1) % NW;
      if (win_invalid[t]) eunf = 1; else mcwp = t;
    end
    @(negedge clk);
    chk(sv && rs ? "R11" : (sv ? "R6" : "R7"), 32'(cwp_o), 32'(mcwp));
    chk(sv && rs ? "R11" : "R8", 32'(overflow), 32'(eovf));
    chk(sv && rs ? "R11" : "R9", 32'(underflow), 32'(eunf));
    wr_en = 0; save_req = 0; restore_req = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NPHYS; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", 32'(cwp_o), 0);
    chk("R1", 32'(overflow), 0);
    chk("R1", 32'(underflow), 0);
    for (int r = 0; r < 32; r++) rd(r, "R1", 32'd0);

    // R2: write to register 0 discarded
    cyc(0, 0, 1, 0, 32'hDEADBEEF, 0, 0);
    rd(0, "R2", 32'd0);

    // R3: globals seen from another window
    cyc(0, 0, 1, 5, 32'h5555_0005, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);                 // R6: 0 -> NW-1
    chk("R6", 32'(cwp_o), NW - 1);
    rd(5, "R3", 32'h5555_0005);

    // R4: locals private per window
    cyc(0, 0, 1, 18, 32'hA000_0018, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1);                 // R7: NW-1 -> 0
    chk("R7", 32'(cwp_o), 0);
    rd(18, "R4", 32'd0);

    // R5: out of window 0 is in of window NW-1
    cyc(0, 0, 1, 11, 32'hB000_000B, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    rd(27, "R5", 32'hB000_000B);
    cyc(0, 0, 0, 0, 0, 0, 1);

    // R10: old value in the write cycle, new value after
    cyc(20, 20, 1, 20, 32'hC000_0014, 0, 0);
    rd(20, "R10", 32'hC000_0014);

    // R12: write to an out together with a save
    cyc(0, 0, 1, 14, 32'hD000_000E, 1, 0);
    rd(30, "R12", 32'hD000_000E);
    cyc(0, 0, 0, 0, 0, 0, 1);

    // R8: refused save, R9: refused restore
    win_invalid = NW'(1) << (NW - 1);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R8", 32'(overflow), 1);
    chk("R8", 32'(cwp_o), 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R8", 32'(overflow), 0);
    win_invalid = NW'(2);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R9", 32'(underflow), 1);
    chk("R9", 32'(cwp_o), 0);
    win_invalid = '0;

    // R11: both requests together
    cyc(0, 0, 0, 0, 0, 1, 1);
    chk("R11", 32'(cwp_o), 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      if (n % 64 == 0) win_invalid = NW'($urandom & $urandom & $urandom);
      cyc($urandom_range(31), $urandom_range(31), $urandom_range(1),
          $urandom_range(31), $urandom, $urandom_range(7) == 0,
          $urandom_range(7) == 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule